// File: doc/BRIEF.md
# Tagged Receive/Transmit Byte FIFO

This block holds the byte queues between a serial link controller and its host. The receive queue is filled by the line receiver. Each entry is one data byte plus three tags: an end-of-frame mark, a CRC-mismatch mark and an overrun mark. The host reads only the byte. The tags of whichever entry sits at the head of the queue are held in a status register, which the host inspects beside the data. The transmit queue is a plain byte queue: the host writes to it and the line transmitter drains it.

If the line receiver pushes while the receive queue is full and the host does not read in the same cycle, the byte is lost. The loss is recorded in the overrun tag of the newest stored entry, so the host sees it when it reaches that entry. Each queue is emptied, and held empty, for as long as its enable input is low. Reset is synchronous and active high.

Top module: `tagged_byte_fifo_pair`

## Requirements
- R1: A line push stores the byte together with its end-of-frame tag (entry bit 8) and CRC tag (entry bit 9). A host read with a non-empty receive queue removes the head entry. On the following clock edge `host_rdata` shows that entry's byte and none of its tags. `host_rdata` holds its value between reads.
- R2: After every clock edge, `stat_eof`, `stat_crc_err` and `stat_overrun` show the tags of the entry then at the head of the receive queue. A newly pushed entry that becomes the head counts. The three flags are all zero when the queue is empty.
- R3: A line push into a full receive queue with no host read in the same cycle is discarded. The level stays the same, and the overrun tag (entry bit 10) of the most recently stored entry is set. That tag appears on `stat_overrun` when the entry reaches the head.
- R4: A line push and a host read in the same cycle on a full receive queue are both accepted. The queue stays full and no overrun tag is set.
- R5: A host read of an empty receive queue returns zero on `host_rdata` on the next edge and leaves the level at zero.
- R6: A host write appends a byte to the transmit queue. `tx_byte` shows the head byte while the queue is not empty, and a line pop removes it in write order.
- R7: A host write into a full transmit queue with no line pop in the same cycle is discarded, and the level stays the same.
- R8: While `rx_enable` is low, the receive queue is empty from the next edge on, line pushes are ignored, host reads return zero, and the status flags are zero.
- R9: While `tx_enable` is low, the transmit queue is empty from the next edge on, and host writes are ignored.
- R10: Reset empties both queues and clears `host_rdata` and the three status flags.
- R11: `rx_level` and `tx_level` give the entry counts. Each full output is high exactly at the depth, and each empty output is high exactly at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_enable | input | 1 | Receive queue enable; low flushes it |
| line_push | input | 1 | Line receiver pushes an entry |
| line_byte | input | 8 | Received byte |
| line_eof | input | 1 | Byte closes its frame |
| line_crc_err | input | 1 | Frame CRC mismatch mark |
| host_rd | input | 1 | Host reads and removes the receive head |
| host_rdata | output | 8 | Byte from the last host read |
| stat_eof | output | 1 | End-of-frame tag of the head entry |
| stat_crc_err | output | 1 | CRC-mismatch tag of the head entry |
| stat_overrun | output | 1 | Overrun tag of the head entry |
| rx_level | output | $clog2(RX_DEPTH+1) | Receive entry count |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| tx_enable | input | 1 | Transmit queue enable; low flushes it |
| host_wr | input | 1 | Host appends a byte |
| host_wdata | input | 8 | Byte to append |
| line_pop | input | 1 | Line transmitter removes the head byte |
| tx_byte | output | 8 | Head byte of the transmit queue (zero when empty) |
| tx_level | output | $clog2(TX_DEPTH+1) | Transmit entry count |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |

## Verification
The bench builds the block with a receive depth of 4 and a transmit depth of 5. The shallow receive queue makes overrun and full-queue push-with-read cases reachable within a few cycles. The transmit depth is not a power of two, so the pointers must wrap at an index that plain binary rollover would not hit. The bench runs a long mixed random phase, with enables toggled now and then, which takes both pointers around their rings many times.

// File: rtl/tbf_pkg.sv
package tbf_pkg;

  localparam int BYTE_W = 8;

  // Stored receive word: bit 8 end of frame, bit 9 CRC mismatch.
  typedef struct packed {
    logic              crc_bad;
    logic              frame_end;
    logic [BYTE_W-1:0] data;
  } rx_word_t;

  // Head tags as shown to the host: {overrun, crc, eof} = entry bits 10..8.
  typedef struct packed {
    logic overrun;
    logic crc_bad;
    logic frame_end;
  } rx_tags_t;

  function automatic int ring_next(input int p, input int depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  function automatic int ring_prev(input int p, input int depth);
    return (p == 0) ? depth - 1 : p - 1;
  endfunction

endpackage

// File: rtl/tbf_ptr_ctl.sv
module tbf_ptr_ctl #(
  parameter int DEPTH = 8,
  parameter int AW    = 3,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign pop_ok  = pop_req && !flush && !empty;
  // a pop in the same cycle frees the slot the push needs
  assign push_ok = push_req && !flush && (!full || pop_ok);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= AW'(tbf_pkg::ring_next(int'(wr_ptr), DEPTH));
      if (pop_ok)  rd_ptr <= AW'(tbf_pkg::ring_next(int'(rd_ptr), DEPTH));
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/tbf_store.sv
module tbf_store #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  parameter int AW    = 3,
  parameter int NRD   = 1
) (
  input  logic                       clk,
  input  logic                       we,
  input  logic [AW-1:0]              waddr,
  input  logic [WIDTH-1:0]           wdata,
  input  logic [NRD-1:0][AW-1:0]     raddr,
  output logic [NRD-1:0][WIDTH-1:0]  rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  generate
    for (genvar g = 0; g < NRD; g++) begin : g_rd
      assign rdata[g] = mem[raddr[g]];
    end
  endgenerate

endmodule

// File: rtl/tbf_ovr_marks.sv
module tbf_ovr_marks #(
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          clr_en,
  input  logic [AW-1:0] clr_idx,
  input  logic          set_en,
  input  logic [AW-1:0] set_idx,
  input  logic [AW-1:0] rd_idx,
  output logic          rd_bit
);

  logic [DEPTH-1:0] marks;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      marks <= '0;
    end else begin
      if (clr_en) marks[clr_idx] <= 1'b0;
      if (set_en) marks[set_idx] <= 1'b1;
    end
  end

  assign rd_bit = marks[rd_idx];

endmodule

// File: rtl/tbf_rx_path.sv
module tbf_rx_path #(
  parameter int DEPTH = 8,
  parameter int AW    = 3,
  parameter int CW    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              push,
  input  logic [7:0]        push_data,
  input  logic              push_eof,
  input  logic              push_crc,
  input  logic              pop,
  output logic [7:0]        rd_data,
  output tbf_pkg::rx_tags_t tags,
  output logic [CW-1:0]     count,
  output logic              full,
  output logic              empty
);

  localparam int WORD_W = $bits(tbf_pkg::rx_word_t);

  logic                         flush;
  logic                         push_ok, pop_ok, drop;
  logic [AW-1:0]                wr_ptr, rd_ptr, rd_ptr_nxt, last_ptr;
  logic [1:0][AW-1:0]           raddr;
  logic [1:0][WORD_W-1:0]       rwords;
  tbf_pkg::rx_word_t            word_in, head_now, head_nxt;
  logic                         mark_nxt;
  logic                         ends_empty, bypass;

  assign flush = !enable;

  tbf_ptr_ctl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ptr (
    .clk(clk), .rst(rst), .flush(flush), .push_req(push), .pop_req(pop),
    .push_ok(push_ok), .pop_ok(pop_ok), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .count(count), .full(full), .empty(empty)
  );

  // lost byte: full, no room freed by a read this cycle
  assign drop       = push && !flush && full && !pop_ok;
  assign rd_ptr_nxt = flush  ? '0 :
                      pop_ok ? AW'(tbf_pkg::ring_next(int'(rd_ptr), DEPTH)) : rd_ptr;
  assign last_ptr   = AW'(tbf_pkg::ring_prev(int'(wr_ptr), DEPTH));

  assign word_in = '{crc_bad: push_crc, frame_end: push_eof, data: push_data};
  assign raddr[0] = rd_ptr;
  assign raddr[1] = rd_ptr_nxt;

  tbf_store #(.WIDTH(WORD_W), .DEPTH(DEPTH), .AW(AW), .NRD(2)) u_store (
    .clk(clk), .we(push_ok), .waddr(wr_ptr), .wdata(word_in),
    .raddr(raddr), .rdata(rwords)
  );

  assign head_now = tbf_pkg::rx_word_t'(rwords[0]);
  assign head_nxt = tbf_pkg::rx_word_t'(rwords[1]);

  tbf_ovr_marks #(.DEPTH(DEPTH), .AW(AW)) u_marks (
    .clk(clk), .rst(rst), .flush(flush),
    .clr_en(push_ok), .clr_idx(wr_ptr),
    .set_en(drop), .set_idx(last_ptr),
    .rd_idx(rd_ptr_nxt), .rd_bit(mark_nxt)
  );

  // queue empty after this edge
  assign ends_empty = flush || (empty && !push_ok) ||
                      ((count == CW'(1)) && pop_ok && !push_ok);
  // the entry written this edge becomes the head; memory not yet holding it
  assign bypass = push_ok && (rd_ptr_nxt == wr_ptr);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      tags    <= '0;
    end else begin
      if (pop) rd_data <= pop_ok ? head_now.data : 8'h00;
      if (ends_empty)  tags <= '0;
      else if (bypass) tags <= tbf_pkg::rx_tags_t'({1'b0, push_crc, push_eof});
      else             tags <= tbf_pkg::rx_tags_t'({mark_nxt, head_nxt.crc_bad, head_nxt.frame_end});
    end
  end

endmodule

// File: rtl/tbf_tx_path.sv
module tbf_tx_path #(
  parameter int DEPTH = 8,
  parameter int AW    = 3,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          wr,
  input  logic [7:0]    wdata,
  input  logic          pop,
  output logic [7:0]    head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic               push_ok, pop_ok;
  logic [AW-1:0]      wr_ptr, rd_ptr;
  logic [0:0][AW-1:0] raddr;
  logic [0:0][7:0]    rbytes;

  tbf_ptr_ctl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ptr (
    .clk(clk), .rst(rst), .flush(!enable), .push_req(wr), .pop_req(pop),
    .push_ok(push_ok), .pop_ok(pop_ok), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .count(count), .full(full), .empty(empty)
  );

  assign raddr[0] = rd_ptr;

  tbf_store #(.WIDTH(8), .DEPTH(DEPTH), .AW(AW), .NRD(1)) u_store (
    .clk(clk), .we(push_ok), .waddr(wr_ptr), .wdata(wdata),
    .raddr(raddr), .rdata(rbytes)
  );

  assign head = empty ? 8'h00 : rbytes[0];

endmodule

// File: rtl/tagged_byte_fifo_pair.sv
module tagged_byte_fifo_pair #(
  parameter int  RX_DEPTH = 8,
  parameter int  TX_DEPTH = 8,
  localparam int RX_AW = (RX_DEPTH > 1) ? $clog2(RX_DEPTH) : 1,
  localparam int RX_CW = $clog2(RX_DEPTH + 1),
  localparam int TX_AW = (TX_DEPTH > 1) ? $clog2(TX_DEPTH) : 1,
  localparam int TX_CW = $clog2(TX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_enable,
  input  logic             line_push,
  input  logic [7:0]       line_byte,
  input  logic             line_eof,
  input  logic             line_crc_err,
  input  logic             host_rd,
  output logic [7:0]       host_rdata,
  output logic             stat_eof,
  output logic             stat_crc_err,
  output logic             stat_overrun,
  output logic [RX_CW-1:0] rx_level,
  output logic             rx_full,
  output logic             rx_empty,
  input  logic             tx_enable,
  input  logic             host_wr,
  input  logic [7:0]       host_wdata,
  input  logic             line_pop,
  output logic [7:0]       tx_byte,
  output logic [TX_CW-1:0] tx_level,
  output logic             tx_full,
  output logic             tx_empty
);

  tbf_pkg::rx_tags_t head_tags;

  tbf_rx_path #(.DEPTH(RX_DEPTH), .AW(RX_AW), .CW(RX_CW)) u_rx (
    .clk(clk), .rst(rst), .enable(rx_enable),
    .push(line_push), .push_data(line_byte), .push_eof(line_eof), .push_crc(line_crc_err),
    .pop(host_rd), .rd_data(host_rdata), .tags(head_tags),
    .count(rx_level), .full(rx_full), .empty(rx_empty)
  );

  assign stat_eof     = head_tags.frame_end;
  assign stat_crc_err = head_tags.crc_bad;
  assign stat_overrun = head_tags.overrun;

  tbf_tx_path #(.DEPTH(TX_DEPTH), .AW(TX_AW), .CW(TX_CW)) u_tx (
    .clk(clk), .rst(rst), .enable(tx_enable),
    .wr(host_wr), .wdata(host_wdata), .pop(line_pop),
    .head(tx_byte), .count(tx_level), .full(tx_full), .empty(tx_empty)
  );

endmodule

// File: rtl/tbf_checker.sv
module tbf_checker #(
  parameter int  RX_DEPTH = 8,
  parameter int  TX_DEPTH = 8,
  localparam int RX_CW = $clog2(RX_DEPTH + 1),
  localparam int TX_CW = $clog2(TX_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_enable,
  input logic             line_push,
  input logic             host_rd,
  input logic [7:0]       host_rdata,
  input logic             stat_eof,
  input logic             stat_crc_err,
  input logic             stat_overrun,
  input logic [RX_CW-1:0] rx_level,
  input logic             rx_full,
  input logic             rx_empty,
  input logic             tx_enable,
  input logic             host_wr,
  input logic             line_pop,
  input logic [TX_CW-1:0] tx_level,
  input logic             tx_full,
  input logic             tx_empty
);

  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (rx_empty && tx_empty && host_rdata == 8'h00 && !stat_eof && !stat_crc_err && !stat_overrun));

  assert_level_bound_R11: assert property (@(posedge clk) disable iff (rst)
    (rx_level <= RX_CW'(RX_DEPTH)) && (tx_level <= TX_CW'(TX_DEPTH)) && !(rx_full && rx_empty) && !(tx_full && tx_empty));

  assert_flags_zero_when_empty_R2: assert property (@(posedge clk) disable iff (rst)
    rx_empty |-> !(stat_eof || stat_crc_err || stat_overrun));

  assert_overrun_keeps_level_R3: assert property (@(posedge clk) disable iff (rst)
    (rx_enable && rx_full && line_push && !host_rd) |=> (rx_full && $stable(rx_level)));

  assert_full_push_pop_R4: assert property (@(posedge clk) disable iff (rst)
    (rx_enable && rx_full && line_push && host_rd) |=> rx_full);

  assert_empty_read_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (rx_empty && host_rd && !line_push) |=> (host_rdata == 8'h00 && rx_empty));

  assert_tx_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (tx_enable && tx_full && host_wr && !line_pop) |=> (tx_full && $stable(tx_level)));

  assert_rx_flush_R8: assert property (@(posedge clk) disable iff (rst)
    !rx_enable |=> (rx_empty && !stat_eof && !stat_crc_err && !stat_overrun));

  assert_tx_flush_R9: assert property (@(posedge clk) disable iff (rst)
    !tx_enable |=> tx_empty);

endmodule

bind tagged_byte_fifo_pair tbf_checker #(.RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .rx_enable(rx_enable), .line_push(line_push), .host_rd(host_rd),
  .host_rdata(host_rdata), .stat_eof(stat_eof), .stat_crc_err(stat_crc_err),
  .stat_overrun(stat_overrun), .rx_level(rx_level), .rx_full(rx_full), .rx_empty(rx_empty),
  .tx_enable(tx_enable), .host_wr(host_wr), .line_pop(line_pop), .tx_level(tx_level),
  .tx_full(tx_full), .tx_empty(tx_empty)
);

// File: tb/sim_tagged_byte_fifo_pair.sv
`timescale 1ns/1ps
module sim_tagged_byte_fifo_pair;

  localparam int RXD = 4;
  localparam int TXD = 5;
  localparam int RCW = $clog2(RXD + 1);
  localparam int TCW = $clog2(TXD + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_enable = 1'b0, line_push = 1'b0, line_eof = 1'b0, line_crc_err = 1'b0, host_rd = 1'b0;
  logic [7:0] line_byte = 8'h00;
  logic tx_enable = 1'b0, host_wr = 1'b0, line_pop = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata, tx_byte;
  logic stat_eof, stat_crc_err, stat_overrun, rx_full, rx_empty, tx_full, tx_empty;
  logic [RCW-1:0] rx_level;
  logic [TCW-1:0] tx_level;

  always #4 clk = ~clk;

  tagged_byte_fifo_pair #(.RX_DEPTH(RXD), .TX_DEPTH(TXD)) u0 (
    .clk(clk), .rst(rst), .rx_enable(rx_enable), .line_push(line_push), .line_byte(line_byte),
    .line_eof(line_eof), .line_crc_err(line_crc_err), .host_rd(host_rd), .host_rdata(host_rdata),
    .stat_eof(stat_eof), .stat_crc_err(stat_crc_err), .stat_overrun(stat_overrun),
    .rx_level(rx_level), .rx_full(rx_full), .rx_empty(rx_empty),
    .tx_enable(tx_enable), .host_wr(host_wr), .host_wdata(host_wdata), .line_pop(line_pop),
    .tx_byte(tx_byte), .tx_level(tx_level), .tx_full(tx_full), .tx_empty(tx_empty)
  );

  int n_chk = 0;
  int n_err = 0;
  bit cmp_on = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model: entry = {ovr, crc, eof, data}
  logic [10:0] rq[$];
  logic [7:0]  tq[$];
  logic [7:0]  m_rdata = 8'h00;
  logic [2:0]  m_stat = 3'b000;

  always @(posedge clk) begin
    bit popped;
    bit was_full;
    logic [10:0] tmp;
    if (rst) begin
      rq.delete(); tq.delete(); m_rdata = 8'h00; m_stat = 3'b000;
    end else begin
      if (!rx_enable) begin
        if (host_rd) m_rdata = 8'h00;
        rq.delete();
      end else begin
        was_full = (rq.size() == RXD);
        popped = 1'b0;
        if (host_rd) begin
          if (rq.size() > 0) begin
            m_rdata = rq[0][7:0];
            void'(rq.pop_front());
            popped = 1'b1;
          end else m_rdata = 8'h00;
        end
        if (line_push) begin
          if (!was_full || popped) rq.push_back({1'b0, line_crc_err, line_eof, line_byte});
          else begin
            tmp = rq[rq.size()-1];
            tmp[10] = 1'b1;
            rq[rq.size()-1] = tmp;
          end
        end
      end
      m_stat = (rq.size() > 0) ? rq[0][10:8] : 3'b000;
      if (!tx_enable) tq.delete();
      else begin
        was_full = (tq.size() == TXD);
        popped = 1'b0;
        if (line_pop && tq.size() > 0) begin void'(tq.pop_front()); popped = 1'b1; end
        if (host_wr && (!was_full || popped)) tq.push_back(host_wdata);
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R11 rx_level", int'(rx_level), rq.size());
      chk("R11 rx_empty", int'(rx_empty), int'(rq.size() == 0));
      chk("R11 rx_full", int'(rx_full), int'(rq.size() == RXD));
      chk("R1 host_rdata", int'(host_rdata), int'(m_rdata));
      chk("R2 status flags", int'({stat_overrun, stat_crc_err, stat_eof}), int'(m_stat));
      chk("R11 tx_level", int'(tx_level), tq.size());
      chk("R11 tx_full", int'(tx_full), int'(tq.size() == TXD));
      chk("R6 tx_byte", int'(tx_byte), (tq.size() > 0) ? int'(tq[0]) : 0);
    end
  end

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    finish_run();
  end

  task automatic rx_put(input logic [7:0] b, input logic e, input logic c);
    line_push = 1'b1; line_byte = b; line_eof = e; line_crc_err = c;
    cyc();
    line_push = 1'b0; line_eof = 1'b0; line_crc_err = 1'b0;
  endtask

  initial begin
    repeat (3) cyc();
    cmp_on = 1'b1;
    chk("R10 rx_empty after reset", int'(rx_empty), 1);
    chk("R10 tx_empty after reset", int'(tx_empty), 1);
    chk("R10 rdata after reset", int'(host_rdata), 0);
    chk("R10 flags after reset", int'({stat_overrun, stat_crc_err, stat_eof}), 0);
    rst = 1'b0; rx_enable = 1'b1; tx_enable = 1'b1;
    cyc();

    // tagged entries, head tags follow the head
    rx_put(8'hA5, 1'b0, 1'b0);
    chk("R2 head flags first entry", int'({stat_overrun, stat_crc_err, stat_eof}), 0);
    rx_put(8'h3C, 1'b1, 1'b0);
    rx_put(8'h7E, 1'b0, 1'b1);
    host_rd = 1'b1;
    cyc();
    chk("R1 read byte", int'(host_rdata), 8'hA5);
    chk("R2 eof of new head", int'(stat_eof), 1);
    cyc();
    chk("R1 read byte 2", int'(host_rdata), 8'h3C);
    chk("R2 crc of new head", int'({stat_crc_err, stat_eof}), 2);
    cyc();
    chk("R1 read byte 3", int'(host_rdata), 8'h7E);
    cyc();
    chk("R5 empty read data", int'(host_rdata), 0);
    chk("R5 empty read level", int'(rx_level), 0);
    host_rd = 1'b0;

    // overrun
    for (int i = 0; i < RXD; i++) rx_put(8'h10 + 8'(i), (i == RXD - 1), 1'b0);
    rx_put(8'h99, 1'b0, 1'b0);
    chk("R3 level after lost push", int'(rx_level), RXD);
    host_rd = 1'b1;
    for (int i = 0; i < RXD - 1; i++) cyc();
    chk("R3 overrun tag on last stored", int'(stat_overrun), 1);
    chk("R3 eof kept with overrun", int'(stat_eof), 1);
    cyc();
    chk("R3 lost byte not stored", int'(host_rdata), 8'h13);
    host_rd = 1'b0;
    cyc();

    // push and read together on full
    for (int i = 0; i < RXD; i++) rx_put(8'h20 + 8'(i), 1'b0, 1'b0);
    host_rd = 1'b1; line_push = 1'b1; line_byte = 8'h24;
    cyc();
    chk("R4 stays full", int'(rx_full), 1);
    chk("R4 read byte", int'(host_rdata), 8'h20);
    line_byte = 8'h25;
    cyc();
    line_push = 1'b0;
    for (int i = 0; i < RXD; i++) begin
      chk("R4 no overrun tag", int'(stat_overrun), 0);
      cyc();
    end
    chk("R4 last byte", int'(host_rdata), 8'h25);
    host_rd = 1'b0;

    // receive flush
    rx_put(8'h30, 1'b1, 1'b1);
    rx_put(8'h31, 1'b0, 1'b0);
    rx_enable = 1'b0;
    cyc();
    chk("R8 flushed level", int'(rx_level), 0);
    chk("R8 flushed flags", int'({stat_overrun, stat_crc_err, stat_eof}), 0);
    rx_put(8'h32, 1'b1, 1'b0);
    chk("R8 push ignored", int'(rx_level), 0);
    rx_enable = 1'b1;
    cyc();

    // transmit
    for (int i = 0; i <= TXD; i++) begin
      host_wr = 1'b1; host_wdata = 8'h40 + 8'(i);
      cyc();
    end
    host_wr = 1'b0;
    chk("R7 dropped write", int'(tx_level), TXD);
    chk("R6 head byte", int'(tx_byte), 8'h40);
    line_pop = 1'b1;
    cyc();
    chk("R6 next byte", int'(tx_byte), 8'h41);
    repeat (TXD - 1) cyc();
    line_pop = 1'b0;
    chk("R6 drained", int'(tx_empty), 1);
    for (int i = 0; i < 14; i++) begin
      host_wr = 1'b1; host_wdata = 8'h50 + 8'(i); line_pop = (i > 1);
      cyc();
    end
    host_wr = 1'b0; line_pop = 1'b0;
    tx_enable = 1'b0;
    cyc();
    chk("R9 tx flushed", int'(tx_empty), 1);
    host_wr = 1'b1; host_wdata = 8'hEE;
    cyc();
    chk("R9 write ignored", int'(tx_level), 0);
    host_wr = 1'b0; tx_enable = 1'b1;
    cyc();

    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      line_push = 1'($urandom % 2); line_byte = 8'($urandom);
      line_eof = 1'($urandom % 2); line_crc_err = 1'($urandom % 2);
      host_rd = ($urandom % 3 == 0);
      host_wr = 1'($urandom % 2); host_wdata = 8'($urandom);
      line_pop = ($urandom % 3 == 0);
      rx_enable = ($urandom % 25 != 0);
      tx_enable = ($urandom % 25 != 0);
      cyc();
    end
    line_push = 1'b0; host_wr = 1'b0; host_rd = 1'b0; line_pop = 1'b0;
    rx_enable = 1'b1; tx_enable = 1'b1;
    repeat (3) cyc();
    finish_run();
  end

endmodule